// File: doc/BRIEF.md
# Receiver error flag and output mute sequencer

This block sits behind a biphase audio receiver's clock recovery and decides three things from the lock status and per-frame events. It decides what the serial audio output carries: demodulated samples, the bypass serial input, or silence. It decides what the error pin shows. It decides which clock feeds the output clock dividers, either the recovered clock or the reference clock. Demodulation itself happens elsewhere. The block only sees the results as single-cycle pulses: a frame strobe aligned to the LR clock, a block-start (preamble B) strobe, a parity-error flag, a non-PCM flag, and a strobe that reports a change in the channel-status sample-rate field.

Timeouts are measured on a 1 kHz tick that the block receives from the reference-clock domain. Once lock is gained, release is paced in audio blocks rather than in time. Once lock is lost, the mute lasts a selectable number of ticks before the bypass input is passed through. Output clock switching follows any change of lock status after a short settling delay, and a fresh change restarts that delay.

Top module: `rx_err_mute_seq`

## Requirements
- R1: While reset is asserted and afterwards until a stimulus arrives, err_o is 1, dsel_o is 2'b00 (muted), clk_src_o is 0 (reference clock) and repl_o is 0.
- R2: After lock_i rises, dsel_o stays muted. It changes to 2'b01 (demodulated) on the clock edge that samples the 3rd pre_b_i pulse (err_wait_i=0) or the 6th (err_wait_i=1).
- R3: Outside the immediate raise of R8 and a loss of lock, the internal error flag changes only on a cycle with frame_i high. After acquisition it stays 1 until the first frame strobe that follows the change to demodulated output.
- R4: After lock is lost, dsel_o stays muted until 5 ms_tick_i pulses (unl_wait_i=0) or 342 pulses (unl_wait_i=1) have been counted. It then becomes 2'b10 (bypass input).
- R5: With force_mute_i=1, the unlocked state stays muted after its timeout. force_mute_i has no effect while demodulated data is selected.
- R6: With np_mute_i=1 and non_pcm_i=1, demodulated output is muted while the error flag stays 0. With np_mute_i=0, non_pcm_i does not change dsel_o.
- R7: A frame with parity_err_i sets the error flag on that frame strobe. When non_pcm_i is 0, it also pulses repl_o for one cycle after that strobe. When non_pcm_i is 1, repl_o stays 0.
- R8: A rate_chg_i pulse while locked sets err_o on the next edge, mutes the output and restarts the block count of R2.
- R9: With err_mode_i=1, err_o is 1 exactly when dsel_o is not muted.
- R10: clk_src_o takes the current lock status (1 = recovered clock) once 3 ms_tick_i pulses have passed with no further status change. Any change in between restarts the count.
- R11: dsel_o never holds 2'b11. Demodulated output appears only with lock present on the previous edge. Bypass output appears only with lock absent on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | Clock recovery locked |
| pre_b_i | input | 1 | Block-start preamble strobe |
| frame_i | input | 1 | Frame strobe, LR-clock aligned |
| parity_err_i | input | 1 | Parity error for the current frame |
| non_pcm_i | input | 1 | Channel-status non-PCM flag |
| rate_chg_i | input | 1 | Channel-status rate field changed between blocks |
| ms_tick_i | input | 1 | 1 kHz timing tick |
| err_wait_i | input | 1 | Acquisition release: 0 = 3 blocks, 1 = 6 blocks |
| unl_wait_i | input | 1 | Unlock mute: 0 = short, 1 = long |
| force_mute_i | input | 1 | Silence instead of bypass while unlocked |
| np_mute_i | input | 1 | Mute demodulated output on non-PCM content |
| err_mode_i | input | 1 | 0 = error flag, 1 = output-active status on err_o |
| err_o | output | 1 | Error or output-active pin |
| dsel_o | output | 2 | Output select: 00 mute, 01 demodulated, 10 bypass |
| repl_o | output | 1 | Repeat previous sample strobe |
| clk_src_o | output | 1 | Output clock source: 0 reference, 1 recovered |

## Verification
The checker watches the output select on every cycle for the illegal code and for demodulated or bypass output that disagrees with the lock input. It also ties each replacement strobe to a preceding parity-error frame, allows the error flag to fall only on a frame strobe, and requires the error pin to follow a rate change or a bypass selection. The exact release counts of 3 or 6 blocks and 5 or 342 ticks, the restart of the clock-switch delay, and the mode table of non-PCM muting, forced mute and status mode can only be shown by the bench's scenarios. Those scenarios count events at the ports and compare the outputs against the count.

// File: rtl/errseq_pkg.sv
package errseq_pkg;
  typedef enum logic [1:0] {
    SEL_MUTE   = 2'b00,
    SEL_DEMOD  = 2'b01,
    SEL_BYPASS = 2'b10
  } out_sel_e;

  typedef enum logic [1:0] {
    ST_UNLK = 2'b00,
    ST_ACQ  = 2'b01,
    ST_RUN  = 2'b10
  } seq_state_e;
endpackage

// File: rtl/errseq_tick_timer.sv
module errseq_tick_timer #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (restart_i)                cnt_q <= '0;
    else if (tick_i && cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q >= limit_i);
endmodule

// File: rtl/errseq_lock_fsm.sv
module errseq_lock_fsm
  import errseq_pkg::*;
#(
  parameter int B_SHORT = 3,
  parameter int B_LONG  = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lock_i,
  input  logic       rate_chg_i,
  input  logic       pre_b_i,
  input  logic       err_wait_i,
  output seq_state_e state_o
);
  localparam int BW = $clog2(B_LONG + 1);

  seq_state_e     state_q, state_d;
  logic [BW-1:0]  bcnt_q, bcnt_d;
  logic [BW-1:0]  need;

  assign need = err_wait_i ? BW'(B_LONG) : BW'(B_SHORT);

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    if (!lock_i || (rate_chg_i && state_q != ST_UNLK)) begin
      state_d = ST_UNLK;   // rate change handled as a lock loss
      bcnt_d  = '0;
    end else begin
      unique case (state_q)
        ST_UNLK: begin
          state_d = ST_ACQ;
          bcnt_d  = '0;
        end
        ST_ACQ: if (pre_b_i) begin
          if (bcnt_q + 1'b1 >= need) state_d = ST_RUN;
          else                      bcnt_d  = bcnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_UNLK;
      bcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/errseq_err_flag.sv
module errseq_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic rate_chg_i,
  input  logic frame_i,
  input  logic parity_err_i,
  input  logic non_pcm_i,
  input  logic running_i,
  output logic err_o,
  output logic repl_o
);
  logic err_q, repl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b1;
      repl_q <= 1'b0;
    end else begin
      if (!lock_i || rate_chg_i) err_q <= 1'b1;
      else if (frame_i)          err_q <= !running_i || parity_err_i;
      repl_q <= frame_i && parity_err_i && !non_pcm_i && running_i && lock_i;
    end
  end

  assign err_o  = err_q;
  assign repl_o = repl_q;
endmodule

// File: rtl/rx_err_mute_seq.sv
module rx_err_mute_seq
  import errseq_pkg::*;
#(
  parameter int B_SHORT   = 3,
  parameter int B_LONG    = 6,
  parameter int UNL_SHORT = 5,
  parameter int UNL_LONG  = 342,
  parameter int CLK_SW    = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lock_i,
  input  logic       pre_b_i,
  input  logic       frame_i,
  input  logic       parity_err_i,
  input  logic       non_pcm_i,
  input  logic       rate_chg_i,
  input  logic       ms_tick_i,
  input  logic       err_wait_i,
  input  logic       unl_wait_i,
  input  logic       force_mute_i,
  input  logic       np_mute_i,
  input  logic       err_mode_i,
  output logic       err_o,
  output logic [1:0] dsel_o,
  output logic       repl_o,
  output logic       clk_src_o
);
  localparam int UW = $clog2(UNL_LONG + 1);
  localparam int CW = $clog2(CLK_SW + 1);

  seq_state_e state;
  out_sel_e   sel;
  logic       unl_done, clk_done, err_flag;
  logic       lk_eff, lk_prev_q, clk_restart, clk_src_q;
  logic [UW-1:0] unl_limit;

  errseq_lock_fsm #(.B_SHORT(B_SHORT), .B_LONG(B_LONG)) u_fsm (
    .clk_i, .rst_ni, .lock_i, .rate_chg_i, .pre_b_i, .err_wait_i,
    .state_o(state)
  );

  assign unl_limit = unl_wait_i ? UW'(UNL_LONG) : UW'(UNL_SHORT);

  errseq_tick_timer #(.W(UW)) u_unl_tmr (
    .clk_i, .rst_ni,
    .restart_i(state != ST_UNLK),
    .tick_i(ms_tick_i),
    .limit_i(unl_limit),
    .done_o(unl_done)
  );

  // clock source follows lock status after a settling delay
  assign lk_eff      = (state != ST_UNLK);
  assign clk_restart = (lk_eff != lk_prev_q);

  errseq_tick_timer #(.W(CW)) u_clk_tmr (
    .clk_i, .rst_ni,
    .restart_i(clk_restart),
    .tick_i(ms_tick_i),
    .limit_i(CW'(CLK_SW)),
    .done_o(clk_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_prev_q <= 1'b0;
      clk_src_q <= 1'b0;
    end else begin
      lk_prev_q <= lk_eff;
      if (!clk_restart && clk_done) clk_src_q <= lk_eff;
    end
  end

  errseq_err_flag u_err (
    .clk_i, .rst_ni, .lock_i, .rate_chg_i, .frame_i, .parity_err_i,
    .non_pcm_i,
    .running_i(state == ST_RUN),
    .err_o(err_flag),
    .repl_o
  );

  always_comb begin
    unique case (state)
      ST_RUN:  sel = (np_mute_i && non_pcm_i) ? SEL_MUTE : SEL_DEMOD;
      ST_ACQ:  sel = SEL_MUTE;
      default: sel = !unl_done ? SEL_MUTE : (force_mute_i ? SEL_MUTE : SEL_BYPASS);
    endcase
  end

  assign dsel_o    = sel;
  assign err_o     = err_mode_i ? (sel != SEL_MUTE) : err_flag;
  assign clk_src_o = clk_src_q;
endmodule

// File: rtl/errseq_chk.sv
module errseq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lock_i,
  input logic       rate_chg_i,
  input logic       frame_i,
  input logic       parity_err_i,
  input logic       non_pcm_i,
  input logic       err_mode_i,
  input logic       err_o,
  input logic       repl_o,
  input logic [1:0] dsel_o
);
  // R11
  legal_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsel_o != 2'b11);
  // R11
  demod_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsel_o == 2'b01) |-> $past(lock_i));
  // R11
  bypass_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsel_o == 2'b10) |-> !$past(lock_i));
  // R7
  repl_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repl_o |-> $past(frame_i && parity_err_i && !non_pcm_i));
  // R3
  err_frame_paced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(err_o) && !err_mode_i && $past(!err_mode_i)) |-> $past(frame_i));
  // R8
  rate_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_chg_i && !err_mode_i) |=> (err_o || err_mode_i));
  // R9
  bypass_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsel_o == 2'b10) |-> err_o);
endmodule

bind rx_err_mute_seq errseq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lock_i(lock_i), .rate_chg_i(rate_chg_i),
  .frame_i(frame_i), .parity_err_i(parity_err_i), .non_pcm_i(non_pcm_i),
  .err_mode_i(err_mode_i), .err_o(err_o), .repl_o(repl_o), .dsel_o(dsel_o)
);

// File: tb/tb_rx_err_mute_seq.sv
module tb_rx_err_mute_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] MUTE = 2'b00, DEMOD = 2'b01, BYP = 2'b10;
  // {err_mode, np_mute, non_pcm, force_mute, exp_dsel[1:0], exp_err}
  localparam logic [6:0] VEC [0:7] = '{
    7'b0000_01_0, 7'b0011_01_0, 7'b0100_01_0, 7'b0110_00_0,
    7'b1001_01_1, 7'b1010_01_1, 7'b1100_01_1, 7'b1111_00_0
  };

  logic clk = 0, rst_n = 0;
  logic lock = 0, pre_b = 0, frame = 0, par = 0, npcm = 0, rchg = 0, tick = 0;
  logic ewait = 0, uwait = 0, fmute = 0, npm = 0, emode = 0;
  logic err, repl, csrc;
  logic [1:0] dsel;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_err_mute_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .lock_i(lock), .pre_b_i(pre_b), .frame_i(frame),
    .parity_err_i(par), .non_pcm_i(npcm), .rate_chg_i(rchg), .ms_tick_i(tick),
    .err_wait_i(ewait), .unl_wait_i(uwait), .force_mute_i(fmute),
    .np_mute_i(npm), .err_mode_i(emode),
    .err_o(err), .dsel_o(dsel), .repl_o(repl), .clk_src_o(csrc)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic tick_n(input int n);
    repeat (n) begin tick = 1; step(); tick = 0; end
  endtask
  task automatic b_n(input int n);
    repeat (n) begin pre_b = 1; step(); pre_b = 0; end
  endtask
  task automatic frm(input logic p);
    frame = 1; par = p; step(); frame = 0; par = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1 reset state
    check("R1", "err", err, 1);   check("R1", "dsel", dsel, MUTE);
    check("R1", "clk_src", csrc, 0); check("R1", "repl", repl, 0);
    rst_n = 1; step(2);
    check("R1", "err after release", err, 1);

    // R4 short unlock mute
    tick_n(4);  check("R4", "dsel after 4 ticks", dsel, MUTE);
    tick_n(1);  check("R4", "dsel after 5 ticks", dsel, BYP);
    // R5 / R9 forced mute and status mode while unlocked
    emode = 1; #1; check("R9", "err bypass", err, 1);
    fmute = 1; #1; check("R5", "dsel forced", dsel, MUTE);
    check("R9", "err muted", err, 0);
    fmute = 0; emode = 0; #1;

    // R2 / R10 acquisition
    lock = 1; step(2);
    check("R2", "dsel acq", dsel, MUTE); check("R2", "err acq", err, 1);
    tick_n(2); step(2); check("R10", "clk_src 2 ticks", csrc, 0);
    tick_n(1); step(2); check("R10", "clk_src 3 ticks", csrc, 1);
    frm(0); check("R3", "err frame in acq", err, 1);
    b_n(2); check("R2", "dsel 2 blocks", dsel, MUTE);
    b_n(1); check("R2", "dsel 3 blocks", dsel, DEMOD);
    check("R3", "err before frame", err, 1);
    step(2); check("R3", "err no frame", err, 1);
    frm(0); check("R3", "err after frame", err, 0);

    // R5 R6 R9 mode table while running
    foreach (VEC[i]) begin
      emode = VEC[i][6]; npm = VEC[i][5]; npcm = VEC[i][4]; fmute = VEC[i][3];
      step();
      check("R6", $sformatf("vec%0d dsel", i), dsel, VEC[i][2:1]);
      check("R9", $sformatf("vec%0d err", i), err, VEC[i][0]);
    end
    emode = 0; npm = 0; npcm = 0; fmute = 0; step();

    // R7 parity
    frm(1); check("R7", "err parity", err, 1); check("R7", "repl", repl, 1);
    step(); check("R7", "repl one cycle", repl, 0);
    frm(0); check("R7", "err cleared", err, 0);
    npcm = 1; frm(1); check("R7", "repl non-pcm", repl, 0);
    check("R7", "err non-pcm", err, 1);
    npcm = 0; frm(0);

    // R8 rate change with long acquisition
    ewait = 1; rchg = 1; step(); rchg = 0;
    check("R8", "err immediate", err, 1);
    step(); check("R8", "dsel muted", dsel, MUTE);
    b_n(5); check("R8", "dsel 5 blocks", dsel, MUTE);
    b_n(1); check("R2", "dsel 6 blocks", dsel, DEMOD);
    frm(0); check("R3", "err after relock", err, 0);

    // R10 restart on status change
    uwait = 1; lock = 0; step(2);
    check("R4", "dsel unlocked", dsel, MUTE); check("R8", "err unlock", err, 1);
    tick_n(2); lock = 1; step(2); tick_n(2); lock = 0; step(2); tick_n(2); step(2);
    check("R10", "clk_src restarted", csrc, 1);
    tick_n(1); step(2); check("R10", "clk_src switched", csrc, 0);

    // R4 long unlock mute (3 ticks so far in this unlock)
    tick_n(338); check("R4", "dsel 341 ticks", dsel, MUTE);
    tick_n(1);   check("R4", "dsel 342 ticks", dsel, BYP);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule